// File: doc/BRIEF.md
# Burst Address Controller

This block is the address and cycle controller that sits in front of the array of a synchronous burst SRAM. On a rising clock edge it registers an external address when either of two address strobes starts a cycle. One strobe comes from the processor side and the other from the memory-controller side. After a start, it produces the following beats of the burst itself. A two-bit beat counter moves forward only when the advance input is high. The low two address bits follow either linear or interleaved order, chosen by a mode input.

For each cycle the block also decodes the global-write, byte-write and byte-select inputs into per-byte write strobes. When no strobe is set, a cycle is a read. Chip enable gates the processor strobe. When chip enable is low, the controller strobe either starts a cycle or puts the part in the deselected state. A state machine tracks this with four states: ST_IDLE (deselected), ST_FIRST (first beat after a load), ST_BURST (a beat reached by advancing) and ST_HOLD (a suspended beat). The transitions are as follows. A load moves any state to ST_FIRST. A controller strobe with chip enable low moves any state to ST_IDLE. An active state goes to ST_BURST when advance is high and to ST_HOLD when it is low. ST_IDLE stays in ST_IDLE without a load.

Top module: `sram_burst_ctl`

## Requirements
- R1: While reset is held and just after it, `arr_act` is 0 and `arr_wstb` is all zeros.
- R2: When `strobe_p` is high with `ce` high, the next cycle presents `addr_in` on `arr_addr` with `arr_act` high and `arr_wstb` zero (a read), whatever the write controls are.
- R3: When `strobe_c` is high with `ce` high and `strobe_p` low, the next cycle presents `addr_in`, and its write strobes are decoded from that edge's write controls.
- R4: With `ce` low, `strobe_p` is ignored. With `ce` low and `strobe_c` high, the next cycle has `arr_act` low (deselected).
- R5: With `order_sel`=0 (linear), each advance gives low bits = start + beat mod 4. Bits above bit 1 never change without a load.
- R6: With `order_sel`=1 (interleaved), each advance gives low bits = start XOR beat. A start of 01 gives 01, 00, 11, 10.
- R7: In an active cycle with no load and `adv` low, `arr_addr` holds its value.
- R8: The fourth advance of a burst returns the low bits to the start value. This is the fifth cycle of the burst.
- R9: With `gw` low and `bw_en` high, `arr_wstb` equals `byte_sel` (bit i = byte i). With both low, no byte is written.
- R10: With `gw` high, every bit of `arr_wstb` is set, whatever `bw_en` and `byte_sel` are. This applies to controller-started and continuation cycles.
- R11: A new address may be loaded on every clock edge, back to back, with no burst in between.
- R12: In the deselected state, `adv` alone has no effect and the block stays deselected.
- R13: When both strobes are high with `ce` high, the processor strobe wins and the cycle is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External address |
| strobe_p | input | 1 | Processor-side address strobe, active high |
| strobe_c | input | 1 | Controller-side address strobe, active high |
| adv | input | 1 | Advance the burst counter |
| ce | input | 1 | Chip enable, active high |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| bw_en | input | 1 | Byte-write enable |
| byte_sel | input | NB | Individual byte selects |
| gw | input | 1 | Global write, all bytes |
| arr_addr | output | AW | Address of the current array cycle |
| arr_wstb | output | NB | Per-byte write strobes for the current cycle |
| arr_act | output | 1 | An array cycle is active (part selected) |
| arr_rd | output | 1 | The active cycle is a read |

## Verification
The hardest cases to reach are the interactions around chip enable. Examples are a processor strobe that is masked while an interleaved burst is in progress, and a controller strobe with chip enable low that must deselect instead of loading. To reach them, the stimulus table first walks a full interleaved burst through its wrap. It then raises the masked processor strobe with a junk address, checks that the burst address is held, and only then issues the deselecting controller strobe followed by a lone advance. Back-to-back loads with conflicting write controls make the write decoding depend on which strobe started the cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2,
        ST_HOLD  = 2'd3
    } sbc_state_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/sbc_order.sv
module sbc_order
    import sbc_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] lo
);
    always_comb begin
        if (interleave) lo = start ^ beat;
        else            lo = start + beat;
    end
endmodule

// File: rtl/sbc_wdec.sv
module sbc_wdec #(
    parameter int NB = 2
) (
    input  logic          allow,
    input  logic          gw,
    input  logic          bw_en,
    input  logic [NB-1:0] sel,
    output logic [NB-1:0] stb
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign stb[i] = allow & (gw | (bw_en & sel[i]));
    end
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
    import sbc_pkg::*;
#(
    parameter int AW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          strobe_p,
    input  logic          strobe_c,
    input  logic          adv,
    input  logic          ce,
    input  logic          order_sel,
    input  logic          bw_en,
    input  logic [NB-1:0] byte_sel,
    input  logic          gw,
    output logic [AW-1:0] arr_addr,
    output logic [NB-1:0] arr_wstb,
    output logic          arr_act,
    output logic          arr_rd
);
    localparam int HW = AW - BEAT_W;

    sbc_state_e        state_q, state_d;
    logic [HW-1:0]     hi_q;
    logic [BEAT_W-1:0] start_q, beat_q, lo_q;
    logic [BEAT_W-1:0] beat_nx, lo_step;
    logic [NB-1:0]     wstb_q, stb_d;
    logic              p_go, c_go, load, active, step, allow;

    assign p_go    = strobe_p & ce;
    assign c_go    = strobe_c & ~p_go;
    assign load    = p_go | (c_go & ce);
    assign active  = (state_q != ST_IDLE);
    assign step    = adv & active & ~p_go & ~c_go;
    assign beat_nx = beat_q + 2'd1;
    // processor-started cycles are reads; deselect writes nothing
    assign allow   = c_go ? ce : (~p_go & active);

    sbc_order u_order (
        .start      (start_q),
        .beat       (beat_nx),
        .interleave (order_sel),
        .lo         (lo_step)
    );

    sbc_wdec #(.NB(NB)) u_wdec (
        .allow (allow),
        .gw    (gw),
        .bw_en (bw_en),
        .sel   (byte_sel),
        .stb   (stb_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (p_go)      state_d = ST_FIRST;
        else if (c_go) state_d = ce ? ST_FIRST : ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:                    state_d = ST_IDLE;
                ST_FIRST, ST_BURST, ST_HOLD: state_d = adv ? ST_BURST : ST_HOLD;
                default:                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
            lo_q    <= '0;
            wstb_q  <= '0;
        end else begin
            if (load) begin
                hi_q    <= addr_in[AW-1:BEAT_W];
                start_q <= addr_in[BEAT_W-1:0];
                beat_q  <= '0;
                lo_q    <= addr_in[BEAT_W-1:0];
            end else if (step) begin
                beat_q <= beat_nx;
                lo_q   <= lo_step;
            end
            wstb_q <= stb_d;
        end
    end

    assign arr_addr = {hi_q, lo_q};
    assign arr_wstb = wstb_q;
    assign arr_act  = active;
    assign arr_rd   = active & (wstb_q == '0);

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_act |-> (arr_wstb == '0));
    a_r2_p_start_read: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_p && ce) |=> (arr_act && arr_wstb == '0));
    a_r4_c_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_c && !ce) |=> !arr_act);
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strobe_p && ce) && !strobe_c) |=> $stable(arr_addr[AW-1:BEAT_W]));
    a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_act && !(strobe_p && ce) && !strobe_c && !adv) |=> $stable(arr_addr));
    a_r10_global_all: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_c && ce && !strobe_p && gw) |=> (arr_wstb == {NB{1'b1}}));
    a_r12_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_act && !strobe_c && !(strobe_p && ce)) |=> !arr_act);
endmodule

// File: tb/sram_burst_ctl_tb.sv
module sram_burst_ctl_tb;
    localparam int AW = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_p = 0, strobe_c = 0, adv = 0, ce = 0, order_sel = 0;
    logic          bw_en = 0, gw = 0;
    logic [NB-1:0] byte_sel = '0;
    logic [AW-1:0] arr_addr;
    logic [NB-1:0] arr_wstb;
    logic          arr_act, arr_rd;
    int            checks = 0, errors = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    sram_burst_ctl #(.AW(AW), .NB(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p(strobe_p),
        .strobe_c(strobe_c), .adv(adv), .ce(ce), .order_sel(order_sel),
        .bw_en(bw_en), .byte_sel(byte_sel), .gw(gw), .arr_addr(arr_addr),
        .arr_wstb(arr_wstb), .arr_act(arr_act), .arr_rd(arr_rd)
    );

    typedef struct packed {
        logic       sp, sc, adv, ce, ord, bw;
        logic [3:0] bsel;
        logic       gw;
        logic [7:0] addr;
        logic       e_act;
        logic [7:0] e_addr;
        logic [3:0] e_wstb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        // sp    sc    adv   ce    ord   bw    bsel   gw    addr    act   eaddr   ewstb  req
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,8'h41,1'b1,8'h41,4'h0,4'd2},  // R2 p-start read
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,8'h00,1'b1,8'h42,4'h0,4'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,8'h00,1'b1,8'h43,4'h0,4'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,8'h00,1'b1,8'h40,4'h0,4'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,8'h00,1'b1,8'h41,4'h0,4'd8},  // R8 wrap
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'h5,1'b0,8'h00,1'b1,8'h41,4'h5,4'd7},  // R7 hold, R9
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'h3,1'b0,8'h9D,1'b1,8'h9D,4'h3,4'd3},  // R3 c-start write
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,1'b0,8'h00,1'b1,8'h9C,4'h0,4'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,1'b0,8'h00,1'b1,8'h9F,4'h0,4'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,1'b0,8'h00,1'b1,8'h9E,4'h0,4'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,1'b0,8'h00,1'b1,8'h9D,4'h0,4'd8},  // R8 wrap
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,8'h00,1'b1,8'h9D,4'h0,4'd4},  // R4 masked
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,8'h00,1'b0,8'h00,4'h0,4'd4},  // R4 deselect
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,8'h00,1'b0,8'h00,4'h0,4'd12}, // R12
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,8'h20,1'b1,8'h20,4'h0,4'd13}, // R13
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,8'h33,1'b1,8'h33,4'hF,4'd10}, // R10, R11
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'h2,1'b1,8'h34,1'b1,8'h34,4'hF,4'd10}, // R10 override
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,8'h35,1'b1,8'h35,4'h0,4'd11}, // R11
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b1,8'h00,1'b1,8'h36,4'hF,4'd10}  // R10 continuation
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        strobe_p = 0; strobe_c = 0; adv = 0; ce = 0; order_sel = 0;
        bw_en = 0; byte_sel = '0; gw = 0; addr_in = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R1", "act in reset", arr_act, 0);
        chk("R1", "wstb in reset", arr_wstb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "act after reset", arr_act, 0);

        for (int i = 0; i < NV; i++) begin
            strobe_p = VEC[i].sp;  strobe_c = VEC[i].sc; adv = VEC[i].adv;
            ce = VEC[i].ce;        order_sel = VEC[i].ord; bw_en = VEC[i].bw;
            byte_sel = VEC[i].bsel; gw = VEC[i].gw;      addr_in = VEC[i].addr;
            @(negedge clk);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("act row %0d", i),
                arr_act, VEC[i].e_act);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("wstb row %0d", i),
                arr_wstb, VEC[i].e_wstb);
            if (VEC[i].e_act)
                chk($sformatf("R%0d", VEC[i].req), $sformatf("addr row %0d", i),
                    arr_addr, VEC[i].e_addr);
        end

        // R1: reset in the middle of a write cycle clears it
        idle_inputs();
        strobe_c = 1; ce = 1; gw = 1; addr_in = 8'h77;
        @(negedge clk);
        chk("R3", "pre-reset wstb", arr_wstb, 4'hF);
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        chk("R1", "act after mid reset", arr_act, 0);
        chk("R1", "wstb after mid reset", arr_wstb, 0);
        rst_n = 1'b1;

        // R12: lone advance after reset
        adv = 1; ce = 1;
        @(negedge clk);
        chk("R12", "adv from idle", arr_act, 0);

        // R9: byte write with no byte chosen reads; arr_rd follows
        idle_inputs();
        strobe_c = 1; ce = 1; bw_en = 1; byte_sel = 4'h0; addr_in = 8'hC2;
        @(negedge clk);
        chk("R9", "empty byte set wstb", arr_wstb, 0);
        chk("R9", "empty byte set read", arr_rd, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule